// File: doc/BRIEF.md
# Qualified Programmable Event Counter

This block is one programmable event counter for a performance-monitoring unit. A number of event sources each present eight sub-event lanes, and each lane carries a small per-cycle count. Software picks one source with an 8-bit event code and chooses which of its lanes to add with an 8-bit lane mask. The masked lanes are summed each cycle, and the sum saturates at 15.

Before the sum reaches the counter it passes through a chain of qualifiers. The first is a threshold compare, which can be inverted. Next comes an optional rising-edge detector, so that occurrences are counted rather than cycles. Then a privilege-level filter, and last a global enable. Software writes one 32-bit configuration word, can preload the 48-bit counter at any time, and reads it directly. When the count wraps past all-ones, a sticky overflow flag is set. That flag can drive an interrupt line.

Configuration word layout (bit positions):

| Bits | Field |
|---|---|
| 7:0 | event code |
| 15:8 | lane mask |
| 23:16 | threshold |
| 24 | count at privilege 1..3 |
| 25 | count at privilege 0 |
| 26 | edge mode |
| 27 | invert |
| 28 | interrupt enable |
| 29 | global enable |

Top module: `qual_event_counter`

## Requirements
- R1: Event code values 0..NUM_SRC-1 select that source's lanes; any other code selects no events. Lane k of source s sits at `evt_i[(s*8+k)*2 +: 2]`. Lane k is added only when lane-mask bit k (configuration bit 8+k) is 1, and all selected lanes are summed.
- R2: The per-cycle sum saturates at 15. For example, eight lanes at 3 give 15, not 24.
- R3: With threshold 0 and edge mode off, the counter adds the raw sum each cycle. The invert bit has no effect in this mode.
- R4: With a nonzero threshold, the counter adds 1 in each cycle where sum >= threshold. If any of threshold bits 7:4 is set, it never counts, whether or not invert is set.
- R5: With invert set and a threshold from 1 to 15, the counter adds 1 in each cycle where sum < threshold.
- R6: In edge mode, the counter adds 1 only in cycles where the qualified condition is true and was false in the previous cycle. With threshold 0, the condition is "sum is nonzero".
- R7: At privilege 0, counting needs bit 25. At privilege 1..3, counting needs bit 24. With both bits clear, every privilege level counts.
- R8: With the global enable (bit 29) clear, the counter holds its value.
- R9: After reset the counter is 0. A counter write loads `cnt_wdata_i` at the next edge, and it takes priority over that cycle's increment. `cnt_o` always shows the counter.
- R10: When an add carries out of the 48-bit counter, the counter keeps the wrapped low bits and `ovf_o` becomes 1. `ovf_o` stays 1 until `ovf_clr_i` is pulsed. If a wrap and a clear happen in the same cycle, the flag stays set.
- R11: `irq_o` is 1 in the cycle after one in which `ovf_o` and the interrupt enable (bit 28) are both 1, and 0 otherwise.
- R12: A configuration write takes effect from the next cycle. The cycle of the write still uses the old settings. A configuration write also clears the edge history. Reset clears the configuration, the flag and the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| evt_i | input | NUM_SRC*LANES*LANE_W | per-cycle lane counts of all sources |
| priv_i | input | 2 | current privilege level |
| cfg_we_i | input | 1 | configuration write strobe |
| cfg_wdata_i | input | 32 | configuration word |
| cnt_we_i | input | 1 | counter preload strobe |
| cnt_wdata_i | input | CNT_W | preload value |
| ovf_clr_i | input | 1 | clear the overflow flag |
| cnt_o | output | CNT_W | counter value |
| ovf_o | output | 1 | sticky overflow flag |
| irq_o | output | 1 | overflow interrupt |

## Verification
A stale or wrong bit of edge history shows on `cnt_o` one edge after the next qualified cycle: an occurrence is either missed or counted twice. A wrong source select or lane mask makes the count drift in the first cycle whose random lanes differ. The carry and flag logic are driven by preloads close to all-ones, so a faulty wrap shows on `ovf_o` at once and on `irq_o` one cycle later. The counter and both flags are compared against the reference model at every clock, so a divergence is reported in the cycle it first appears.

// File: rtl/qec_pkg.sv
package qec_pkg;
  typedef struct packed {
    logic [1:0] spare;
    logic       count_en;
    logic       irq_en;
    logic       inv_cmp;
    logic       edge_det;
    logic       ring0_en;
    logic       ring_hi_en;
    logic [7:0] thresh;
    logic [7:0] umask;
    logic [7:0] evt_code;
  } qec_cfg_t;

  localparam int CFG_W = $bits(qec_cfg_t);
endpackage

// File: rtl/qec_event_mux.sv
module qec_event_mux #(
  parameter int NUM_SRC = 4,
  parameter int LANES   = 8,
  parameter int LANE_W  = 2,
  parameter int SUM_W   = 4
) (
  input  logic [NUM_SRC*LANES*LANE_W-1:0] evt_i,
  input  logic [7:0]                      code_i,
  input  logic [LANES-1:0]                umask_i,
  output logic [SUM_W-1:0]                sum_o
);
  localparam int SRC_W = LANES * LANE_W;
  localparam int RAW_W = LANE_W + $clog2(LANES) + 1;
  localparam logic [RAW_W-1:0] SAT = RAW_W'((1 << SUM_W) - 1);

  logic [SRC_W-1:0]  src;
  logic [LANE_W-1:0] lane_v [LANES];
  logic [RAW_W-1:0]  raw;

  // source select: unknown codes give an all-zero source
  always_comb begin
    src = '0;
    for (int s = 0; s < NUM_SRC; s++)
      if (code_i == 8'(s)) src = evt_i[s*SRC_W +: SRC_W];
  end

  genvar k;
  generate
    for (k = 0; k < LANES; k++) begin : g_lane
      assign lane_v[k] = umask_i[k] ? src[k*LANE_W +: LANE_W] : '0;
    end
  endgenerate

  always_comb begin
    raw = '0;
    for (int j = 0; j < LANES; j++) raw = raw + RAW_W'(lane_v[j]);
  end

  assign sum_o = (raw > SAT) ? SAT[SUM_W-1:0] : raw[SUM_W-1:0];
endmodule

// File: rtl/qec_qualifier.sv
module qec_qualifier
  import qec_pkg::*;
#(
  parameter int SUM_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_hist_i,
  input  qec_cfg_t         cfg_i,
  input  logic [SUM_W-1:0] sum_i,
  input  logic [1:0]       priv_i,
  output logic [SUM_W-1:0] inc_o
);
  logic hi_bits, priv_ok, gate, thr_zero, ge, cond, qual, prev_q;

  assign hi_bits  = |cfg_i.thresh[7:SUM_W];
  assign priv_ok  = (!cfg_i.ring0_en && !cfg_i.ring_hi_en) ||
                    ((priv_i == 2'd0) ? cfg_i.ring0_en : cfg_i.ring_hi_en);
  assign gate     = cfg_i.count_en && priv_ok;
  assign thr_zero = (cfg_i.thresh == 8'd0);
  assign ge       = (sum_i >= cfg_i.thresh[SUM_W-1:0]);
  assign cond     = thr_zero ? (sum_i != '0) : (!hi_bits && (ge ^ cfg_i.inv_cmp));
  assign qual     = gate && cond;

  always_ff @(posedge clk) begin
    if (rst || clr_hist_i) prev_q <= 1'b0;
    else                   prev_q <= qual;
  end

  always_comb begin
    if (cfg_i.edge_det)  inc_o = {{(SUM_W-1){1'b0}}, qual && !prev_q};
    else if (thr_zero)   inc_o = gate ? sum_i : '0;
    else                 inc_o = {{(SUM_W-1){1'b0}}, qual};
  end

  // R6: an edge is counted once, never in two consecutive cycles
  a_r6_edge_once: assert property (@(posedge clk) disable iff (rst)
    (cfg_i.edge_det && inc_o != '0 && !clr_hist_i) |=> (inc_o == '0));
  // R4: thresholds above the sum range never count
  a_r4_hi_thresh: assert property (@(posedge clk) disable iff (rst)
    (|cfg_i.thresh[7:SUM_W]) |-> (inc_o == '0));
  // R7: privilege-0-only setting ignores other levels
  a_r7_priv_filter: assert property (@(posedge clk) disable iff (rst)
    (cfg_i.ring0_en && !cfg_i.ring_hi_en && priv_i != 2'd0) |-> (inc_o == '0));
endmodule

// File: rtl/qec_accum.sv
module qec_accum #(
  parameter int CNT_W = 48,
  parameter int INC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [INC_W-1:0] inc_i,
  input  logic             clr_ovf_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] nxt;
  logic             carry;

  assign {carry, nxt} = {1'b0, cnt_o} + (CNT_W+1)'(inc_i);

  always_ff @(posedge clk) begin
    if (rst)         cnt_o <= '0;
    else if (load_i) cnt_o <= load_val_i;
    else             cnt_o <= nxt;
  end

  always_ff @(posedge clk) begin
    if (rst)                  ovf_o <= 1'b0;
    else if (!load_i && carry) ovf_o <= 1'b1;
    else if (clr_ovf_i)       ovf_o <= 1'b0;
  end

  // R9: a preload lands at the next edge
  a_r9_preload: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_o == $past(load_val_i)));
  // R10: the flag is sticky until cleared
  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !clr_ovf_i) |=> ovf_o);
  // R10: wrapping from all-ones raises the flag
  a_r10_wrap: assert property (@(posedge clk) disable iff (rst)
    (!load_i && cnt_o == '1 && inc_i != '0) |=> ovf_o);
endmodule

// File: rtl/qual_event_counter.sv
module qual_event_counter
  import qec_pkg::*;
#(
  parameter int CNT_W   = 48,
  parameter int NUM_SRC = 4,
  parameter int LANES   = 8,
  parameter int LANE_W  = 2,
  parameter int SUM_W   = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_SRC*LANES*LANE_W-1:0] evt_i,
  input  logic [1:0]                      priv_i,
  input  logic                            cfg_we_i,
  input  logic [31:0]                     cfg_wdata_i,
  input  logic                            cnt_we_i,
  input  logic [CNT_W-1:0]                cnt_wdata_i,
  input  logic                            ovf_clr_i,
  output logic [CNT_W-1:0]                cnt_o,
  output logic                            ovf_o,
  output logic                            irq_o
);
  qec_cfg_t         cfg_q;
  logic [SUM_W-1:0] sum, inc;

  always_ff @(posedge clk) begin
    if (rst)           cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= qec_cfg_t'(cfg_wdata_i);
  end

  qec_event_mux #(.NUM_SRC(NUM_SRC), .LANES(LANES), .LANE_W(LANE_W), .SUM_W(SUM_W)) u_mux (
    .evt_i(evt_i), .code_i(cfg_q.evt_code), .umask_i(cfg_q.umask[LANES-1:0]), .sum_o(sum));

  qec_qualifier #(.SUM_W(SUM_W)) u_qual (
    .clk(clk), .rst(rst), .clr_hist_i(cfg_we_i), .cfg_i(cfg_q),
    .sum_i(sum), .priv_i(priv_i), .inc_o(inc));

  qec_accum #(.CNT_W(CNT_W), .INC_W(SUM_W)) u_acc (
    .clk(clk), .rst(rst), .load_i(cnt_we_i), .load_val_i(cnt_wdata_i),
    .inc_i(inc), .clr_ovf_i(ovf_clr_i), .cnt_o(cnt_o), .ovf_o(ovf_o));

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= ovf_o && cfg_q.irq_en;
  end

  // R8: disabled counter holds unless preloaded
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!cfg_q.count_en && !cnt_we_i) |=> $stable(cnt_o));
  // R11: interrupt follows an enabled flag
  a_r11_irq_set: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && cfg_q.irq_en) |=> irq_o);
  // R11: no interrupt without the flag
  a_r11_irq_clr: assert property (@(posedge clk) disable iff (rst)
    (!ovf_o) |=> !irq_o);
endmodule

// File: tb/tb_qual_event_counter.sv
module tb_qual_event_counter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] evt = '0;
  logic [1:0]  priv = '0;
  logic        cfg_we = 1'b0, cnt_we = 1'b0, ovf_clr = 1'b0;
  logic [31:0] cfg_wd = '0;
  logic [47:0] cnt_wd = '0;
  logic [47:0] cnt;
  logic        ovf, irq;

  always #2.5 clk = ~clk;

  qual_event_counter dut (
    .clk(clk), .rst(rst), .evt_i(evt), .priv_i(priv),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd), .cnt_we_i(cnt_we),
    .cnt_wdata_i(cnt_wd), .ovf_clr_i(ovf_clr),
    .cnt_o(cnt), .ovf_o(ovf), .irq_o(irq));

  int    checks = 0, fails = 0;
  string tag = "R9";
  bit    done = 0;

  logic [47:0] m_cnt = '0;
  logic [31:0] m_cfg = '0;
  bit m_ovf = 0, m_irq = 0, m_prev = 0;

  function automatic logic [31:0] mk(input int code, input int umask, input int thr,
      input bit usr, input bit os, input bit edg, input bit inv, input bit ie, input bit en);
    return {2'b00, en, ie, inv, edg, os, usr, thr[7:0], umask[7:0], code[7:0]};
  endfunction

  task automatic tick();
    int sum, inc, thr, code;
    bit pok, cond, q, wrap;
    logic [48:0] nx;
    if (rst) begin
      m_cnt = '0; m_cfg = '0; m_ovf = 0; m_irq = 0; m_prev = 0;
    end else begin
      sum = 0; code = int'(m_cfg[7:0]); thr = int'(m_cfg[23:16]);
      if (code < 4)
        for (int k = 0; k < 8; k++)
          if (m_cfg[8+k]) sum += int'(evt[(code*8+k)*2 +: 2]);
      if (sum > 15) sum = 15;
      pok = (!m_cfg[24] && !m_cfg[25]) || ((priv == 0) ? m_cfg[25] : m_cfg[24]);
      if (thr == 0)      cond = (sum != 0);
      else if (thr > 15) cond = 0;
      else               cond = m_cfg[27] ? (sum < thr) : (sum >= thr);
      q = m_cfg[29] && pok && cond;
      if (m_cfg[26])     inc = (q && !m_prev) ? 1 : 0;
      else if (thr == 0) inc = (m_cfg[29] && pok) ? sum : 0;
      else               inc = q ? 1 : 0;
      m_irq = m_ovf && m_cfg[28];
      wrap = 0;
      if (cnt_we) m_cnt = cnt_wd;
      else begin
        nx = {1'b0, m_cnt} + 49'(inc);
        wrap = nx[48]; m_cnt = nx[47:0];
      end
      if (wrap) m_ovf = 1; else if (ovf_clr) m_ovf = 0;
      m_prev = cfg_we ? 0 : q;
      if (cfg_we) m_cfg = cfg_wd;
    end
    @(posedge clk); #1;
    checks++;
    if (cnt !== m_cnt || ovf !== m_ovf || irq !== m_irq) begin
      fails++;
      $display("FAIL %s: cnt=%h ovf=%b irq=%b expected cnt=%h ovf=%b irq=%b",
               tag, cnt, ovf, irq, m_cnt, m_ovf, m_irq);
    end
    cfg_we = 0; cnt_we = 0; ovf_clr = 0;
  endtask

  task automatic wcfg(input logic [31:0] w);
    cfg_wd = w; cfg_we = 1; tick();
  endtask

  task automatic run(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      case (mode)
        0: evt = {$urandom, $urandom};
        1: evt = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
        2: evt = '1;
        default: evt = (($urandom % 3) == 0) ? {$urandom, $urandom} : '0;
      endcase
      priv = 2'($urandom);
      tick();
    end
  endtask

  initial begin
    #500000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(7));
    tag = "R12 reset"; tick(); tick(); rst = 0; tick();
    tag = "R12 write timing"; evt = '1; wcfg(mk(0, 'hFF, 0, 0, 0, 0, 0, 0, 1)); run(3, 2);
    tag = "R1 select";  wcfg(mk(1, 'h05, 0, 0, 0, 0, 0, 0, 1)); run(40, 0);
    tag = "R1 lane7";   wcfg(mk(2, 'h80, 0, 0, 0, 0, 0, 0, 1)); run(30, 0);
    tag = "R1 bad code"; wcfg(mk(9, 'hFF, 0, 0, 0, 0, 0, 0, 1)); run(20, 0);
    tag = "R2 saturate"; wcfg(mk(3, 'hFF, 0, 0, 0, 0, 0, 0, 1)); run(10, 2);
    tag = "R3 raw inv";  wcfg(mk(0, 'h3C, 0, 0, 0, 0, 1, 0, 1)); run(30, 0);
    tag = "R4 thresh";   wcfg(mk(1, 'hFF, 5, 0, 0, 0, 0, 0, 1)); run(40, 0);
    tag = "R4 hi bits";  wcfg(mk(1, 'hFF, 'h13, 0, 0, 0, 1, 0, 1)); run(20, 0);
    tag = "R5 invert";   wcfg(mk(2, 'h0F, 4, 0, 0, 0, 1, 0, 1)); run(40, 0);
    tag = "R6 edge";     wcfg(mk(0, 'h01, 1, 0, 0, 1, 0, 0, 1)); run(60, 3);
    tag = "R6 edge thr0"; wcfg(mk(0, 'h03, 0, 0, 0, 1, 0, 0, 1)); run(60, 1);
    tag = "R12 hist clear"; evt = '1; run(3, 2);
    wcfg(mk(0, 'h03, 0, 0, 0, 1, 0, 0, 1)); run(4, 2);
    tag = "R7 ring0";    wcfg(mk(1, 'hFF, 0, 0, 1, 0, 0, 0, 1)); run(40, 0);
    tag = "R7 ring123";  wcfg(mk(1, 'hFF, 0, 1, 0, 0, 0, 0, 1)); run(40, 0);
    tag = "R7 neither";  wcfg(mk(1, 'hFF, 0, 0, 0, 0, 0, 0, 1)); run(40, 0);
    tag = "R8 disabled"; wcfg(mk(1, 'hFF, 0, 0, 0, 0, 0, 0, 0)); run(20, 0);
    tag = "R9 preload";  wcfg(mk(3, 'hFF, 0, 0, 0, 0, 0, 0, 1));
    evt = '1; cnt_wd = 48'h1234_5678_9ABC; cnt_we = 1; tick(); run(5, 2);
    tag = "R10 wrap"; cnt_wd = 48'hFFFF_FFFF_FFF8; cnt_we = 1; tick(); run(3, 2);
    tag = "R10 sticky"; wcfg(mk(3, 'hFF, 0, 0, 0, 0, 0, 0, 0)); run(5, 0);
    tag = "R10 clear"; ovf_clr = 1; tick(); run(3, 0);
    tag = "R10 clear vs wrap"; wcfg(mk(3, 'hFF, 0, 0, 0, 0, 0, 0, 1));
    cnt_wd = 48'hFFFF_FFFF_FFFA; cnt_we = 1; tick(); evt = '1; ovf_clr = 1; tick(); run(3, 2);
    tag = "R11 irq"; ovf_clr = 1; tick();
    wcfg(mk(3, 'hFF, 0, 0, 0, 0, 0, 1, 1));
    cnt_wd = 48'hFFFF_FFFF_FFF0; cnt_we = 1; tick(); run(4, 2);
    ovf_clr = 1; tick(); run(3, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule